// File: doc/BRIEF.md
# Sixteen-Bit Reloading Timer with Capture and Baud Overflow

This block is a 16-bit up counter with a companion 16-bit register that holds either a reload value or a captured count. A control byte and a mode byte choose how it behaves. In auto-reload operation the counter reloads itself on overflow and, optionally, when the trigger pin falls. In that same operation it can instead count in either direction, with the trigger pin level picking the direction. In capture operation a trigger fall records the running count. In baud operation each overflow reloads the counter and sends out a one-cycle pulse that a serial shifter can use as its bit clock, and the overflow flag stays clear.

The count source is either the machine-cycle strobe `tick` or falling edges on the count pin. Both pins are sampled only on `tick`, so one edge needs two consecutive strobes to be seen. Software reads every register through a combinational read port and writes through a one-cycle write strobe. All pins here are plain control and status lines. No data stream crosses the boundary, so there is no back-pressure to manage.

Top module: `tmr16_capreload`

## Requirements
- R1: After reset every register reads 0 (addresses 0 to 5), and `ovf_flag`, `ext_flag` and `baud_tick` are 0.
- R2: When control bit 1 is 0, the count rises by one on each clock with `tick` high. When it is 1, the count rises only on a `tick` where `cnt_pin` is 0 and was 1 at the previous `tick`.
- R3: In auto-reload operation (control bits 5, 4 and 0 at 0, mode bit 0 at 0), a step from FFFFh loads the reload register into the count and sets the overflow flag (control bit 7, port `ovf_flag`).
- R4: In auto-reload operation with control bit 3 set, a trigger-pin fall loads the reload register into the count and sets the external flag (control bit 6, port `ext_flag`). The fall is `trig_pin` 0 at a `tick` after it was 1 at the previous `tick`. With bit 3 clear, the fall has no effect.
- R5: With mode bit 0 set in auto-reload operation, `trig_pin` at 1 counts up and at 0 counts down. A down step taken while the count equals the reload value loads FFFFh and sets the overflow flag. Trigger falls neither reload nor set a flag.
- R6: With control bit 0 set (capture), the count only rises, whatever mode bit 0 holds. A step from FFFFh wraps to 0000h and sets the overflow flag. With bit 3 set, a trigger fall copies the count held before that clock into the reload/capture register and sets the external flag.
- R7: With control bit 5 or 4 set (baud), a step from FFFFh loads the reload register, pulses `baud_tick` high for exactly the following cycle, and leaves the overflow flag clear. A trigger fall with bit 3 set raises the external flag and leaves the count alone.
- R8: With the run bit (control bit 2) at 0, the count, the flags and the reload/capture register hold, whatever `tick`, `cnt_pin` and `trig_pin` do.
- R9: Register map: 0 control, 1 mode, 2 count low, 3 count high, 4 reload low, 5 reload high. A count-byte write wins over a hardware step in the same cycle. Writing 0 to a flag bit clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 1 | Synchronised external count pin |
| trig_pin | input | 1 | Synchronised trigger/direction pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| ovf_flag | output | 1 | Overflow flag (control bit 7) |
| ext_flag | output | 1 | External-event flag (control bit 6) |
| baud_tick | output | 1 | One-cycle pulse on baud-mode overflow |

## Verification
A wrong count shows at the count bytes on the very next read, because every step is visible one clock later. A wrong overflow point shows as a reload value appearing one step early or late, with the overflow flag set or clear against expectation. Faulty edge sampling shows as a count that is off by one edge, or a capture value that is off by one step, after a single pin pulse. A baud overflow that leaks into the flag shows as control bit 7 set after the first reload.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_MODE   = 3'd1,
    RA_CNT_LO = 3'd2,
    RA_CNT_HI = 3'd3,
    RA_RLD_LO = 3'd4,
    RA_RLD_HI = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic ovf;
    logic ext;
    logic rx_sel;
    logic tx_sel;
    logic exen;
    logic run;
    logic ext_src;
    logic cap;
  } ctrl_t;

  typedef enum logic [1:0] {
    OP_RELOAD,
    OP_UPDOWN,
    OP_CAPTURE,
    OP_BAUD
  } op_mode_e;
endpackage

// File: rtl/tmr16_fall.sv
module tmr16_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    smp_q <= 1'b0;
    else if (tick) smp_q <= pin;
  end

  assign fall = tick & smp_q & ~pin;
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_mode_e          mode,
  input  logic              step,
  input  logic              trg,
  input  logic              dir_up,
  input  logic [CNT_W-1:0]  rld,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_set,
  output logic              ext_set,
  output logic              cap_load,
  output logic              baud_tick
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, nxt;
  logic             ovf_raw, baud_raw, at_top, cnt_wr;

  assign at_top = (cnt_q == TOP);
  assign cnt_wr = wr_lo | wr_hi;

  always_comb begin
    nxt      = cnt_q;
    ovf_raw  = 1'b0;
    baud_raw = 1'b0;
    ext_set  = 1'b0;
    cap_load = 1'b0;
    unique case (mode)
      OP_RELOAD: begin
        if (step) begin
          if (at_top) begin nxt = rld; ovf_raw = 1'b1; end
          else nxt = cnt_q + ONE;
        end
        if (trg) begin nxt = rld; ext_set = 1'b1; end
      end
      OP_UPDOWN: begin
        if (step) begin
          if (dir_up) begin
            if (at_top) begin nxt = rld; ovf_raw = 1'b1; end
            else nxt = cnt_q + ONE;
          end else begin
            if (cnt_q == rld) begin nxt = TOP; ovf_raw = 1'b1; end
            else nxt = cnt_q - ONE;
          end
        end
      end
      OP_CAPTURE: begin
        if (step) begin nxt = cnt_q + ONE; ovf_raw = at_top; end
        if (trg) begin cap_load = 1'b1; ext_set = 1'b1; end
      end
      OP_BAUD: begin
        if (step) begin
          if (at_top) begin nxt = rld; baud_raw = 1'b1; end
          else nxt = cnt_q + ONE;
        end
        if (trg) ext_set = 1'b1;
      end
      default: nxt = cnt_q;
    endcase
  end

  assign ovf_set = ovf_raw & ~cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      baud_tick <= 1'b0;
    end else begin
      baud_tick <= baud_raw & ~cnt_wr;
      if (cnt_wr)
        cnt_q <= {wr_hi ? HI_W'(wdata) : cnt_q[CNT_W-1:BYTE_W],
                  wr_lo ? wdata : cnt_q[BYTE_W-1:0]};
      else
        cnt_q <= nxt;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovf_set,
  input  logic              ext_set,
  input  logic              cap_load,
  input  logic [CNT_W-1:0]  count,
  output ctrl_t             ctrl,
  output logic [BYTE_W-1:0] mode_byte,
  output logic [CNT_W-1:0]  rld
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      mode_byte <= '0;
      rld       <= '0;
    end else begin
      if (wr_en && wr_addr == RA_CTRL) ctrl <= ctrl_t'(wr_data);
      if (ovf_set) ctrl.ovf <= 1'b1;
      if (ext_set) ctrl.ext <= 1'b1;
      if (wr_en && wr_addr == RA_MODE) mode_byte <= wr_data;
      if (cap_load) rld <= count;
      else if (wr_en && wr_addr == RA_RLD_LO) rld[BYTE_W-1:0] <= wr_data;
      else if (wr_en && wr_addr == RA_RLD_HI) rld[CNT_W-1:BYTE_W] <= HI_W'(wr_data);
    end
  end
endmodule

// File: rtl/tmr16_capreload.sv
module tmr16_capreload
  import tmr16_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              baud_tick
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  ctrl_t             ctrl;
  logic [BYTE_W-1:0] mode_byte;
  logic [CNT_W-1:0]  rld, count;
  logic              cnt_fall, trig_fall, step, trg;
  logic              ovf_set, ext_set, cap_load;
  op_mode_e          mode;

  tmr16_fall u_cnt_edge  (.clk(clk), .rst_n(rst_n), .tick(tick), .pin(cnt_pin),  .fall(cnt_fall));
  tmr16_fall u_trig_edge (.clk(clk), .rst_n(rst_n), .tick(tick), .pin(trig_pin), .fall(trig_fall));

  always_comb begin
    if (ctrl.rx_sel || ctrl.tx_sel) mode = OP_BAUD;
    else if (ctrl.cap)              mode = OP_CAPTURE;
    else if (mode_byte[0])          mode = OP_UPDOWN;
    else                            mode = OP_RELOAD;
  end

  assign step = ctrl.run & (ctrl.ext_src ? cnt_fall : tick);
  assign trg  = ctrl.run & ctrl.exen & trig_fall;

  tmr16_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .step(step), .trg(trg),
    .dir_up(trig_pin), .rld(rld),
    .wr_lo(wr_en && wr_addr == RA_CNT_LO),
    .wr_hi(wr_en && wr_addr == RA_CNT_HI),
    .wdata(wr_data), .count(count), .ovf_set(ovf_set), .ext_set(ext_set),
    .cap_load(cap_load), .baud_tick(baud_tick)
  );

  tmr16_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ovf_set(ovf_set), .ext_set(ext_set),
    .cap_load(cap_load), .count(count), .ctrl(ctrl),
    .mode_byte(mode_byte), .rld(rld)
  );

  always_comb begin
    case (rd_addr)
      RA_CTRL:   rd_data = ctrl;
      RA_MODE:   rd_data = mode_byte;
      RA_CNT_LO: rd_data = count[BYTE_W-1:0];
      RA_CNT_HI: rd_data = BYTE_W'(count[CNT_W-1:BYTE_W]);
      RA_RLD_LO: rd_data = rld[BYTE_W-1:0];
      RA_RLD_HI: rd_data = BYTE_W'(rld[CNT_W-1:BYTE_W]);
      default:   rd_data = '0;
    endcase
  end

  assign ovf_flag = ctrl.ovf;
  assign ext_flag = ctrl.ext;
endmodule

// File: rtl/tmr16_capreload_chk.sv
module tmr16_capreload_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       ctrl_bits,
  input logic             dcen,
  input logic             trig_pin,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             ext_flag,
  input logic             baud_tick
);
  logic baud_sel, cap_sel;
  assign baud_sel = ctrl_bits[5] | ctrl_bits[4];
  assign cap_sel  = ctrl_bits[0];

  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_bits[2] && !wr_en) |=> $stable(count));

  p_baud_no_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_sel && !ovf_flag && !wr_en) |=> !ovf_flag);

  p_baud_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> ($past(baud_sel) && $past(ctrl_bits[2])));

  p_cap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_sel && !baud_sel && !wr_en) |=>
      (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

  p_down_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag) && $past(dcen && !cap_sel && !baud_sel && !trig_pin && !wr_en))
      |-> (count == '1));

  p_ext_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flag) |-> $past(ctrl_bits[3] || wr_en));
endmodule

bind tmr16_capreload tmr16_capreload_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_bits(ctrl),
  .dcen(mode_byte[0]), .trig_pin(trig_pin), .count(count),
  .ovf_flag(ovf_flag), .ext_flag(ext_flag), .baud_tick(baud_tick)
);

// File: tb/tmr16_capreload_bench.sv
`timescale 1ns/1ps
module tmr16_capreload_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cnt_pin = 1'b0, trig_pin = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       ovf_flag, ext_flag, baud_tick;
  int         vec = 0, fails = 0;

  always #2.5 clk = ~clk;

  tmr16_capreload u_tmr16_capreload (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .baud_tick(baud_tick)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vec++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); v = {hi, lo};
  endtask

  task automatic set16(input logic [2:0] a, input logic [15:0] v);
    wr(a, v[7:0]); wr(a + 3'd1, v[15:8]);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, c;
    logic [7:0]  b;
    logic        f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin rd(3'(a), b); chk("R1 reg", {8'h0, b}, 16'h0); end
    chk("R1 flags", {13'h0, ovf_flag, ext_flag, baud_tick}, 16'h0);

    // R3 sweep: auto-reload up
    for (int si = 0; si < 4; si++) begin
      for (int ri = 0; ri < 3; ri++) begin
        for (int n = 1; n <= 8; n++) begin
          logic [15:0] s, r;
          s = (si == 0) ? 16'hFFF9 : (si == 1) ? 16'hFFFC : (si == 2) ? 16'hFFFE : 16'hFFFF;
          r = (ri == 0) ? 16'h0000 : (ri == 1) ? 16'h1234 : 16'hFFFD;
          wr(3'd0, 8'h00); set16(3'd2, s); set16(3'd4, r); wr(3'd0, 8'h04);
          ticks(n);
          c = s; f = 1'b0;
          for (int k = 0; k < n; k++) begin
            if (c == 16'hFFFF) begin c = r; f = 1'b1; end else c = c + 16'd1;
          end
          rd16(3'd2, v); chk("R3 count", v, c);
          chk("R3 ovf", {15'h0, ovf_flag}, {15'h0, f});
        end
      end
    end

    // R2 timer mode ignores cycles without tick
    wr(3'd0, 8'h00); set16(3'd2, 16'h0100); wr(3'd0, 8'h04);
    repeat (5) @(negedge clk);
    rd16(3'd2, v); chk("R2 no tick", v, 16'h0100);

    // R2 counter mode: falls on cnt_pin
    wr(3'd0, 8'h00); set16(3'd2, 16'h0000); wr(3'd0, 8'h06);
    ticks(3);
    rd16(3'd2, v); chk("R2 pin low", v, 16'h0000);
    for (int k = 1; k <= 5; k++) begin
      cnt_pin = 1'b1; ticks(1); cnt_pin = 1'b0; ticks(1);
      rd16(3'd2, v); chk("R2 edges", v, 16'(k));
    end
    cnt_pin = 1'b1; ticks(2);
    rd16(3'd2, v); chk("R2 pin high", v, 16'h0005);
    cnt_pin = 1'b0; ticks(1);

    // R4 trigger reload (counter mode, pin idle => no steps)
    wr(3'd0, 8'h06); set16(3'd2, 16'h0055); set16(3'd4, 16'hABCD);
    trig_pin = 1'b1; ticks(1); trig_pin = 1'b0; ticks(1);
    rd16(3'd2, v); chk("R4 exen off", v, 16'h0055);
    chk("R4 exen off flag", {15'h0, ext_flag}, 16'h0);
    wr(3'd0, 8'h0E);
    trig_pin = 1'b1; ticks(1); trig_pin = 1'b0; ticks(1);
    rd16(3'd2, v); chk("R4 reload", v, 16'hABCD);
    chk("R4 ext flag", {14'h0, ovf_flag, ext_flag}, 16'h1);

    // R9 flag clear and write precedence
    wr(3'd0, 8'h00);
    chk("R9 clear", {14'h0, ovf_flag, ext_flag}, 16'h0);
    set16(3'd2, 16'h0010); wr(3'd0, 8'h04);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h77;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd16(3'd2, v); chk("R9 write wins", v, 16'h0077);

    // R5 down sweep (trig_pin 0)
    wr(3'd0, 8'h00); wr(3'd1, 8'h01); trig_pin = 1'b0;
    for (int si = 0; si < 3; si++) begin
      for (int ri = 0; ri < 2; ri++) begin
        for (int n = 1; n <= 6; n++) begin
          logic [15:0] s, r;
          s = (si == 0) ? 16'h0003 : (si == 1) ? 16'h0001 : 16'h0000;
          r = (ri == 0) ? 16'h0000 : 16'h0002;
          wr(3'd0, 8'h00); set16(3'd2, s); set16(3'd4, r); wr(3'd0, 8'h0C);
          ticks(n);
          c = s; f = 1'b0;
          for (int k = 0; k < n; k++) begin
            if (c == r) begin c = 16'hFFFF; f = 1'b1; end else c = c - 16'd1;
          end
          rd16(3'd2, v); chk("R5 down count", v, c);
          chk("R5 down ovf", {15'h0, ovf_flag}, {15'h0, f});
          chk("R5 no ext", {15'h0, ext_flag}, 16'h0);
        end
      end
    end
    // R5 up direction
    wr(3'd0, 8'h00); set16(3'd2, 16'hFFFE); set16(3'd4, 16'h0040);
    trig_pin = 1'b1; wr(3'd0, 8'h04); ticks(3);
    rd16(3'd2, v); chk("R5 up count", v, 16'h0041);
    chk("R5 up ovf", {15'h0, ovf_flag}, 16'h1);
    trig_pin = 1'b0; ticks(1);

    // R6 capture
    wr(3'd1, 8'h00); wr(3'd0, 8'h00); set16(3'd2, 16'h0100); set16(3'd4, 16'h0000);
    trig_pin = 1'b1; wr(3'd0, 8'h0D); ticks(3);
    trig_pin = 1'b0; ticks(1);
    rd16(3'd4, v); chk("R6 captured", v, 16'h0103);
    rd16(3'd2, v); chk("R6 count", v, 16'h0104);
    chk("R6 ext", {15'h0, ext_flag}, 16'h1);
    wr(3'd0, 8'h00); wr(3'd1, 8'h01); set16(3'd2, 16'hFFFE); wr(3'd0, 8'h05);
    ticks(3);
    rd16(3'd2, v); chk("R6 wrap up only", v, 16'h0001);
    chk("R6 wrap ovf", {15'h0, ovf_flag}, 16'h1);
    rd16(3'd4, v); chk("R6 reg kept", v, 16'h0103);

    // R7 baud
    wr(3'd1, 8'h00); wr(3'd0, 8'h00); set16(3'd2, 16'hFFFE); set16(3'd4, 16'h1234);
    wr(3'd0, 8'h2C);
    ticks(1); chk("R7 no tick yet", {15'h0, baud_tick}, 16'h0);
    ticks(1); chk("R7 tick", {15'h0, baud_tick}, 16'h1);
    rd16(3'd2, v); chk("R7 reload", v, 16'h1234);
    chk("R7 no ovf", {15'h0, ovf_flag}, 16'h0);
    @(negedge clk); chk("R7 one cycle", {15'h0, baud_tick}, 16'h0);
    trig_pin = 1'b1; ticks(1); trig_pin = 1'b0; ticks(1);
    rd16(3'd2, v); chk("R7 trig count", v, 16'h1236);
    chk("R7 ext", {14'h0, ovf_flag, ext_flag}, 16'h1);
    wr(3'd0, 8'h00); set16(3'd2, 16'hFFFF); wr(3'd0, 8'h14);
    ticks(1); chk("R7 tx sel tick", {15'h0, baud_tick}, 16'h1);
    chk("R7 tx no ovf", {15'h0, ovf_flag}, 16'h0);

    // R8 stopped
    wr(3'd0, 8'h00); set16(3'd2, 16'h4444); set16(3'd4, 16'h5555); wr(3'd0, 8'h09);
    ticks(5);
    trig_pin = 1'b1; ticks(1); trig_pin = 1'b0; ticks(1);
    rd16(3'd2, v); chk("R8 count hold", v, 16'h4444);
    rd16(3'd4, v); chk("R8 reg hold", v, 16'h5555);
    chk("R8 flags", {14'h0, ovf_flag, ext_flag}, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end
endmodule